// File: doc/BRIEF.md
# Instruction cache next-line predictor

This block keeps, for every line of a set-associative instruction cache, a pointer to the line that fetch should visit next. The pointer has two parts: the set index of the next line and the way that holds it. On each cycle the fetch unit presents the set and way of the line it is reading. One cycle later the block returns the predicted next set and way, so the fetch unit can start the following access without first decoding branches or adding offsets to the program counter.

An entry that has never been trained points to the sequential successor. That is the next set, with wrap from the last set back to set 0, in way 0. This is the right guess when no branch in the line is taken. When the back end finds a taken branch, or finds that a prediction was wrong, it writes the actual next set and way into the entry of the line concerned. When the cache refills a line with new contents, the entry falls back to the sequential default. Line data, tag compare and branch resolution live outside this block.

Top module: `nlp_next_line_pred`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pred_valid` is 0. After reset every entry predicts the sequential successor in way 0.
- R2: `pred_valid` is 1 exactly in the cycle after a cycle with `lkp_valid` high. `pred_set` and `pred_way` belong to that lookup.
- R3: For an entry that has not been trained, the prediction is set `lkp_set+1` with way 0, whatever the value of `lkp_way`.
- R4: The sequential successor of set SETS-1 is set 0.
- R5: Each update writes `upd_next_set`/`upd_next_way` into the entry addressed by `upd_set`/`upd_way`. A later lookup of that entry returns those values.
- R6: A lookup and an update of the same entry in the same cycle return the entry's old prediction. The new value appears from the next lookup onward.
- R7: A refill (`fill_en`) of an entry returns it to the sequential default for all later lookups. A lookup of that entry in the refill cycle still sees the old value.
- R8: If a refill and an update address the same entry in one cycle, the refill wins and the entry holds the sequential default.
- R9: Entries are kept per set and per way. An update of one way leaves the other ways of the same set unchanged.
- R10: In a cycle after a cycle with `lkp_valid` low, `pred_valid` is 0, even if updates or refills occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_set | input | SET_W | Set index of the line being fetched |
| lkp_way | input | WAY_W | Way of the line being fetched |
| pred_valid | output | 1 | Prediction present (one cycle after lookup) |
| pred_set | output | SET_W | Predicted next set index |
| pred_way | output | WAY_W | Predicted next way |
| upd_en | input | 1 | Write a corrected pointer |
| upd_set | input | SET_W | Set of the line being corrected |
| upd_way | input | WAY_W | Way of the line being corrected |
| upd_next_set | input | SET_W | Actual next set to store |
| upd_next_way | input | WAY_W | Actual next way to store |
| fill_en | input | 1 | Line refilled: restore sequential default |
| fill_set | input | SET_W | Set of the refilled line |
| fill_way | input | WAY_W | Way of the refilled line |

## Verification
The assertions check on every cycle the one-cycle lookup latency and the rules for the per-entry trained flag: a refill clears it and wins over an update in the same cycle, and an update sets it. They also check that the sequential successor wraps at the last set. The bench scenarios are needed to show that the stored set and way come back intact, that a same-cycle lookup sees the old contents, and that one way's training leaves the neighbouring ways untouched. For this the bench compares every prediction against a behavioural table that follows the requirements.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  // Which source drives the prediction outputs
  typedef enum logic {
    SRC_SEQ   = 1'b0,
    SRC_TABLE = 1'b1
  } pred_src_e;
endpackage

// File: rtl/nlp_ptr_ram.sv
// Pointer storage: one write port, one registered read port, read-first.
module nlp_ptr_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= mem[ra];
  end
endmodule

// File: rtl/nlp_entry_valid.sv
// One trained flag per entry; cleared by reset and refill, set by update.
module nlp_entry_valid #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic          rd_q
);
  localparam int N = 1 << AW;

  logic [N-1:0] vbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      vbits <= '0;
    end else begin
      if (set_en) vbits[set_idx] <= 1'b1;
      if (clr_en) vbits[clr_idx] <= 1'b0;  // refill has priority
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= 1'b0;
    else if (re) rd_q <= vbits[ra];
  end

  assert_fill_clears_R7: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !vbits[$past(clr_idx)]);

  assert_fill_beats_update_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_en && clr_idx == set_idx) |=> !vbits[$past(set_idx)]);

  assert_update_marks_R5: assert property (@(posedge clk) disable iff (rst)
    (set_en && !(clr_en && clr_idx == set_idx)) |=> vbits[$past(set_idx)]);
endmodule

// File: rtl/nlp_seq_gen.sv
// Registered sequential-successor set index with wrap.
module nlp_seq_gen #(
  parameter int SETS  = 64,
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             re,
  input  logic [SET_W-1:0] cur_set,
  output logic [SET_W-1:0] seq_q
);
  localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);

  always_ff @(posedge clk) begin
    if (rst)     seq_q <= '0;
    else if (re) seq_q <= (cur_set == LAST) ? '0 : cur_set + 1'b1;
  end

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (re && cur_set == LAST) |=> seq_q == '0);
endmodule

// File: rtl/nlp_next_line_pred.sv
module nlp_next_line_pred
  import nlp_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lkp_valid,
  input  logic [SET_W-1:0] lkp_set,
  input  logic [WAY_W-1:0] lkp_way,
  output logic             pred_valid,
  output logic [SET_W-1:0] pred_set,
  output logic [WAY_W-1:0] pred_way,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [SET_W-1:0] upd_next_set,
  input  logic [WAY_W-1:0] upd_next_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way
);
  localparam int AW = SET_W + WAY_W;
  localparam int DW = SET_W + WAY_W;

  logic [AW-1:0] lkp_idx, upd_idx, fill_idx;
  logic [DW-1:0] ram_q;
  logic          trained_q;
  logic [SET_W-1:0] seq_q;
  logic          valid_q;
  pred_src_e     src;

  assign lkp_idx  = {lkp_set, lkp_way};
  assign upd_idx  = {upd_set, upd_way};
  assign fill_idx = {fill_set, fill_way};

  nlp_ptr_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk  (clk),
    .we   (upd_en),
    .wa   (upd_idx),
    .wd   ({upd_next_set, upd_next_way}),
    .re   (lkp_valid),
    .ra   (lkp_idx),
    .rd_q (ram_q)
  );

  nlp_entry_valid #(.AW(AW)) vld_i (
    .clk     (clk),
    .rst     (rst),
    .set_en  (upd_en),
    .set_idx (upd_idx),
    .clr_en  (fill_en),
    .clr_idx (fill_idx),
    .re      (lkp_valid),
    .ra      (lkp_idx),
    .rd_q    (trained_q)
  );

  nlp_seq_gen #(.SETS(SETS), .SET_W(SET_W)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .re      (lkp_valid),
    .cur_set (lkp_set),
    .seq_q   (seq_q)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= lkp_valid;
  end

  assign src        = trained_q ? SRC_TABLE : SRC_SEQ;
  assign pred_valid = valid_q;
  assign pred_set   = (src == SRC_TABLE) ? ram_q[DW-1:WAY_W] : seq_q;
  assign pred_way   = (src == SRC_TABLE) ? ram_q[WAY_W-1:0]  : '0;

  assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> pred_valid);

  assert_idle_no_pred_R10: assert property (@(posedge clk) disable iff (rst)
    !lkp_valid |=> !pred_valid);
endmodule

// File: tb/nlp_next_line_pred_tb_top.sv
module nlp_next_line_pred_tb_top;
  localparam int SETS  = 64;
  localparam int WAYS  = 4;
  localparam int SET_W = 6;
  localparam int WAY_W = 2;
  localparam int NENT  = SETS * (1 << WAY_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 1'b0;
  logic [SET_W-1:0] lkp_set = '0;
  logic [WAY_W-1:0] lkp_way = '0;
  logic pred_valid;
  logic [SET_W-1:0] pred_set;
  logic [WAY_W-1:0] pred_way;
  logic upd_en = 1'b0;
  logic [SET_W-1:0] upd_set = '0, upd_next_set = '0;
  logic [WAY_W-1:0] upd_way = '0, upd_next_way = '0;
  logic fill_en = 1'b0;
  logic [SET_W-1:0] fill_set = '0;
  logic [WAY_W-1:0] fill_way = '0;

  always #2 clk = ~clk;  // 250 MHz

  nlp_next_line_pred #(.SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_set(lkp_set), .lkp_way(lkp_way),
    .pred_valid(pred_valid), .pred_set(pred_set), .pred_way(pred_way),
    .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way),
    .upd_next_set(upd_next_set), .upd_next_way(upd_next_way),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way)
  );

  typedef struct {
    int         due;
    bit         vld;
    int         eset;
    int         eway;
    string      req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural table built from the requirements
  bit m_tr [NENT];
  int m_set [NENT];
  int m_way [NENT];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs with queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pred_valid !== e.vld) begin
        errors++;
        $display("FAIL %s: pred_valid=%0b expected %0b", e.req, pred_valid, e.vld);
      end else if (e.vld) begin
        checks++;
        if (pred_set !== SET_W'(e.eset) || pred_way !== WAY_W'(e.eway)) begin
          errors++;
          $display("FAIL %s: next=(%0d,%0d) expected (%0d,%0d)",
                   e.req, pred_set, pred_way, e.eset, e.eway);
        end
      end
    end
  end

  // Driver: one cycle of stimulus; push expectation before applying writes
  task automatic step(input bit lv, input int ls, input int lw,
                      input bit ue, input int us, input int uw, input int uns, input int unw,
                      input bit fe, input int fs, input int fw, input string req);
    exp_t e;
    int li;
    li = ls * (1 << WAY_W) + lw;
    lkp_valid = lv; lkp_set = SET_W'(ls); lkp_way = WAY_W'(lw);
    upd_en = ue; upd_set = SET_W'(us); upd_way = WAY_W'(uw);
    upd_next_set = SET_W'(uns); upd_next_way = WAY_W'(unw);
    fill_en = fe; fill_set = SET_W'(fs); fill_way = WAY_W'(fw);
    e.due = cyc + 1;
    e.vld = lv;
    e.req = req;
    if (lv && m_tr[li]) begin
      e.eset = m_set[li]; e.eway = m_way[li];
    end else begin
      e.eset = (ls == SETS - 1) ? 0 : ls + 1; e.eway = 0;
    end
    q.push_back(e);
    if (ue) begin
      int ui = us * (1 << WAY_W) + uw;
      m_tr[ui] = 1; m_set[ui] = uns; m_way[ui] = unw;
    end
    if (fe) m_tr[fs * (1 << WAY_W) + fw] = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input int s, input int w, input string req);
    step(1, s, w, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin m_tr[i] = 0; m_set[i] = 0; m_way[i] = 0; end
    // R1: reset holds prediction invalid even with lookup asserted
    lkp_valid = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (pred_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: pred_valid=%0b during reset expected 0", pred_valid);
    end
    rst = 1'b0;
    lkp_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (pred_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: pred_valid=%0b after reset expected 0", pred_valid);
    end

    // R1/R3: untrained entries give sequential successor, way 0
    look(0, 0, "R1");
    look(12, 3, "R3");
    look(30, 1, "R3");
    // R4: wrap at the last set
    look(SETS - 1, 2, "R4");

    // R5: train an entry, then look it up
    step(0, 0, 0, 1, 5, 2, 40, 3, 0, 0, 0, "R10");
    look(5, 2, "R5");
    // R9: other ways of set 5 stay sequential
    look(5, 0, "R9");
    look(5, 1, "R9");
    look(5, 3, "R9");

    // R6: same-cycle lookup and update returns old value
    step(1, 7, 0, 1, 7, 0, 20, 1, 0, 0, 0, "R6");
    look(7, 0, "R6");
    step(1, 7, 0, 1, 7, 0, 33, 2, 0, 0, 0, "R6");
    look(7, 0, "R6");

    // R7: refill restores default; lookup in refill cycle sees old value
    step(1, 5, 2, 0, 0, 0, 0, 0, 1, 5, 2, "R7");
    look(5, 2, "R7");

    // R8: refill and update to same entry: refill wins
    step(0, 0, 0, 1, 9, 3, 50, 1, 1, 9, 3, "R10");
    look(9, 3, "R8");

    // R10: idle cycles with writes
    step(0, 0, 0, 1, 11, 1, 2, 2, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 0, "R10");
    look(11, 1, "R5");

    // R4/R5: train last set, wrapped pointer
    step(0, 0, 0, 1, SETS - 1, 1, 0, 2, 0, 0, 0, "R10");
    look(SETS - 1, 1, "R5");
    look(SETS - 1, 0, "R4");

    // Back-to-back training and lookups across many sets
    for (int s = 0; s < SETS; s++) begin
      step(1, (s + 17) % SETS, s % WAYS, 1, s, s % WAYS, (s * 7 + 3) % SETS, (s + 1) % WAYS,
           0, 0, 0, "R5");
    end
    for (int s = 0; s < SETS; s++) begin
      look(s, s % WAYS, "R5");
      look(s, (s + 2) % WAYS, "R9");
    end

    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule